// File: doc/BRIEF.md
# Chained-Device Serial Packet Receiver

This block takes the one-bit serial stream that an upstream device in a chain drives into this device. It finds packet boundaries by hunting for a fixed sync codeword. It protects each 32-bit header with a single-error-correct, double-error-detect code and repairs single-bit faults in place. Sync packets are dropped. Heartbeat headers, data headers and the payload words that follow them are written one per strobe into a ring-buffer write port that lies outside the block. A line that sits at one level for too long is flagged as stuck. In bypass, the serial data and flow-control paths route straight from input to output and the receiver stands still.

The receiver is built around a four-state machine with these states:
- HUNT compares every incoming bit position against the sync codeword.
- CHECK confirms that further sync codewords arrive on the 32-bit grid.
- HEAD collects and decodes one header. It is the first locked state.
- PAY collects 10-bit payload words. It is the second locked state.

The transitions are:
- hunt-match: HUNT to CHECK.
- confirm: CHECK stays in CHECK, or goes to HEAD on the third sync in a row.
- miss: CHECK to HUNT.
- double-error drop: HEAD to HUNT.
- payload-start: HEAD to PAY, for a data header with a non-zero count.
- payload-end: PAY to HEAD.
- stuck-abort: any state to HUNT.

A low enable (the clock-gate equivalent) freezes every register.

Top module: `dchain_rx`

## Requirements
- R1: After reset the outputs `locked`, `stuck` and `buf_wr` are 0. Lock needs three sync codewords in a row on one 32-bit grid, compared exactly. The sync header data is 0x2D36B0, and its type field is 0. A non-sync word during CHECK returns the block to HUNT with the count cleared. `locked` is 1 in HEAD and PAY only.
- R2: While locked, a header of type 0 (sync) or type 3 (reserved) causes no write and has no payload.
- R3: A header with exactly one flipped bit, including the overall-parity bit, is corrected. The written header equals the original 26 data bits.
- R4: A header with two flipped bits causes no write. The block returns to HUNT, so `locked` goes to 0.
- R5: Header data has these fields: type in bits [1:0] (1 = heartbeat, 2 = data), word count in bits [11:2], and tag in bits [25:12]. Each accepted header is written with `buf_hdr`=1. A data header is followed by exactly as many 10-bit payload words as its word count, each written with `buf_hdr`=0 and zero-extended. A heartbeat has no payload, whatever its count field holds.
- R6: After 64 consecutive equal input samples, `stuck` is 1 and lock is lost on the next cycle. The first toggle clears `stuck`.
- R7: With `bypass`=1, `link_out`=`din` and `busy_out`=`busy_in`, and the receiver state is frozen. With `bypass`=0, `link_out`=`ser_in` and `busy_out`=`local_busy`.
- R8: With `en`=0, all receiver state holds and no write strobe is issued. Reception resumes where it stopped once `en` returns to 1.
- R9: The codeword has the overall parity in bit 0 and the Hamming parity bits at positions 1, 2, 4, 8 and 16. The data bits occupy the remaining positions 3 to 31 in ascending order, from data bit 0 upward. Codewords and payload words arrive most significant bit first, one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Receiver enable; 0 freezes all state |
| bypass | input | 1 | 1 routes chain input straight to outputs |
| din | input | 1 | Serial stream from upstream device |
| busy_in | input | 1 | Flow-control from the next device |
| ser_in | input | 1 | This device's own serializer output |
| local_busy | input | 1 | This device's own flow-control |
| link_out | output | 1 | Serial output toward the next device |
| busy_out | output | 1 | Flow-control toward the upstream device |
| locked | output | 1 | Receiver aligned to packet grid |
| stuck | output | 1 | Input has not toggled for the stuck window |
| buf_wr | output | 1 | Ring-buffer write strobe |
| buf_hdr | output | 1 | Written word is a header |
| buf_data | output | 26 | Corrected header data or payload word |

## Verification
The bench sends headers with a flip in a data bit, a flip in the overall-parity bit, and a two-bit flip. A decoder that mis-indexed a position would write a wrong header, and one that fixed double errors would keep writing while it should be unlocked. It sends a data header whose count is zero, and a heartbeat whose count field is non-zero. A payload counter that was off by one would then swallow the next header. Other tests put a non-sync word in the middle of acquisition, hold the line at a level for exactly 63 and then 64 samples, and drop the enable halfway through a header. These catch early lock, a stuck threshold that is off by one, and state that drifts while frozen.

// File: rtl/dchain_pkg.sv
`timescale 1ns/1ps
package dchain_pkg;
    localparam int CW_W   = 32;
    localparam int HD_W   = 26;
    localparam int WORD_W = 10;

    typedef enum logic [1:0] {S_HUNT, S_CHECK, S_HEAD, S_PAY} rx_state_t;

    localparam logic [1:0] TY_BEAT = 2'd1;
    localparam logic [1:0] TY_DATA = 2'd2;

    localparam logic [HD_W-1:0] SYNC_DATA = 26'h2D36B0;

    // SECDED encode: data in non power-of-two positions, Hamming parity at 2^b, overall at 0
    function automatic logic [CW_W-1:0] secded_enc(input logic [HD_W-1:0] d);
        logic [CW_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 5; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW_W; p++)
                if (((p >> b) & 1) == 1 && p != (1 << b)) x = x ^ c[p];
            c[1 << b] = x;
        end
        c[0] = ^c[CW_W-1:1];
        return c;
    endfunction

    localparam logic [CW_W-1:0] SYNC_CW = secded_enc(SYNC_DATA);
endpackage

// File: rtl/dchain_hdr_dec.sv
`timescale 1ns/1ps
module dchain_hdr_dec
    import dchain_pkg::*;
(
    input  logic [CW_W-1:0] cw,
    output logic [HD_W-1:0] data,
    output logic            dbl_err
);
    logic [4:0]      syn;
    logic            par;
    logic [CW_W-1:0] fixed;
    int              k;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++)
            if (cw[p]) syn = syn ^ 5'(p);
        par     = ^cw;
        dbl_err = !par && (syn != 5'd0);
        fixed   = cw;
        if (par) fixed[syn] = ~cw[syn];
        data = '0;
        k    = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                data[k] = fixed[p];
                k++;
            end
        end
    end
endmodule

// File: rtl/dchain_stuck_mon.sv
`timescale 1ns/1ps
module dchain_stuck_mon #(
    parameter int STUCK_N = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic stuck
);
    localparam int RW = $clog2(STUCK_N + 1);

    logic [RW-1:0] run_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            prev_q <= 1'b0;
        end else if (en) begin
            prev_q <= din;
            if (din == prev_q && run_q != '0) begin
                if (run_q != RW'(STUCK_N)) run_q <= run_q + 1'b1;
            end else begin
                run_q <= RW'(1);
            end
        end
    end

    assign stuck = (run_q == RW'(STUCK_N));

    AST_STUCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && din != prev_q) |=> !stuck); // R6
endmodule

// File: rtl/dchain_rx_fsm.sv
`timescale 1ns/1ps
module dchain_rx_fsm
    import dchain_pkg::*;
#(
    parameter int LOCK_N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            din,
    input  logic            stuck,
    output logic            locked,
    output logic            wr,
    output logic            wr_hdr,
    output logic [HD_W-1:0] wr_data
);
    localparam int SW = $clog2(LOCK_N + 1);

    rx_state_t       state_q, state_d;
    logic [4:0]      bit_q, bit_d;
    logic [SW-1:0]   syncs_q, syncs_d;
    logic [9:0]      left_q, left_d;
    logic [CW_W-2:0] sh_q;
    logic [CW_W-1:0] sh_n;
    logic            wr_q, wr_d, hdr_q, hdr_d;
    logic [HD_W-1:0] data_q, data_d;
    logic [HD_W-1:0] dec_data;
    logic            dec_dbl;
    logic            hdr_end, word_end;

    assign sh_n     = {sh_q, din};
    assign hdr_end  = (bit_q == 5'(CW_W - 1));
    assign word_end = (bit_q == 5'(WORD_W - 1));

    dchain_hdr_dec u_dec (
        .cw      (sh_n),
        .data    (dec_data),
        .dbl_err (dec_dbl)
    );

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q + 5'd1;
        syncs_d = syncs_q;
        left_d  = left_q;
        wr_d    = 1'b0;
        hdr_d   = hdr_q;
        data_d  = data_q;
        unique case (state_q)
            S_HUNT: begin
                bit_d = '0;
                if (sh_n == SYNC_CW) begin
                    state_d = S_CHECK;
                    syncs_d = SW'(1);
                end
            end
            S_CHECK: begin
                if (hdr_end) begin
                    bit_d = '0;
                    if (sh_n == SYNC_CW) begin
                        syncs_d = syncs_q + SW'(1);
                        if (syncs_q + SW'(1) == SW'(LOCK_N)) state_d = S_HEAD;
                    end else begin
                        state_d = S_HUNT;
                        syncs_d = '0;
                    end
                end
            end
            S_HEAD: begin
                if (hdr_end) begin
                    bit_d = '0;
                    if (dec_dbl) begin
                        state_d = S_HUNT;
                        syncs_d = '0;
                    end else if (dec_data[1:0] == TY_BEAT || dec_data[1:0] == TY_DATA) begin
                        wr_d   = 1'b1;
                        hdr_d  = 1'b1;
                        data_d = dec_data;
                        if (dec_data[1:0] == TY_DATA && dec_data[11:2] != 10'd0) begin
                            state_d = S_PAY;
                            left_d  = dec_data[11:2];
                        end
                    end
                end
            end
            S_PAY: begin
                if (word_end) begin
                    bit_d  = '0;
                    wr_d   = 1'b1;
                    hdr_d  = 1'b0;
                    data_d = HD_W'(sh_n[WORD_W-1:0]);
                    left_d = left_q - 10'd1;
                    if (left_q == 10'd1) state_d = S_HEAD;
                end
            end
        endcase
        if (stuck) begin
            state_d = S_HUNT;
            syncs_d = '0;
            bit_d   = '0;
            wr_d    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HUNT;
            bit_q   <= '0;
            syncs_q <= '0;
            left_q  <= '0;
            sh_q    <= '0;
            wr_q    <= 1'b0;
            hdr_q   <= 1'b0;
            data_q  <= '0;
        end else if (run) begin
            state_q <= state_d;
            bit_q   <= bit_d;
            syncs_q <= syncs_d;
            left_q  <= left_d;
            sh_q    <= sh_n[CW_W-2:0];
            wr_q    <= wr_d;
            hdr_q   <= hdr_d;
            data_q  <= data_d;
        end else begin
            wr_q    <= 1'b0;
        end
    end

    assign locked  = (state_q == S_HEAD) || (state_q == S_PAY);
    assign wr      = wr_q;
    assign wr_hdr  = hdr_q;
    assign wr_data = data_q;

    AST_WR_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> $past(locked)); // R5
    AST_NO_WR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !wr_q); // R8
    AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(state_q)); // R8
    AST_DBL_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !stuck && state_q == S_HEAD && hdr_end && dec_dbl) |=> (state_q == S_HUNT)); // R4
    AST_STUCK_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stuck) |=> !locked); // R6
endmodule

// File: rtl/dchain_rx.sv
`timescale 1ns/1ps
module dchain_rx
    import dchain_pkg::*;
#(
    parameter int STUCK_N = 64,
    parameter int LOCK_N  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            bypass,
    input  logic            din,
    input  logic            busy_in,
    input  logic            ser_in,
    input  logic            local_busy,
    output logic            link_out,
    output logic            busy_out,
    output logic            locked,
    output logic            stuck,
    output logic            buf_wr,
    output logic            buf_hdr,
    output logic [HD_W-1:0] buf_data
);
    logic run;

    assign run      = en && !bypass;
    assign link_out = bypass ? din : ser_in;
    assign busy_out = bypass ? busy_in : local_busy;

    dchain_stuck_mon #(.STUCK_N(STUCK_N)) u_stuck (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .din   (din),
        .stuck (stuck)
    );

    dchain_rx_fsm #(.LOCK_N(LOCK_N)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .din     (din),
        .stuck   (stuck),
        .locked  (locked),
        .wr      (buf_wr),
        .wr_hdr  (buf_hdr),
        .wr_data (buf_data)
    );
endmodule

// File: tb/test_dchain_rx.sv
`timescale 1ns/1ps
module test_dchain_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, bypass = 1'b0, din = 1'b0;
    logic busy_in = 1'b0, ser_in = 1'b0, local_busy = 1'b0;
    logic link_out, busy_out, locked, stuck, buf_wr, buf_hdr;
    logic [25:0] buf_data;

    int nchk = 0, nfail = 0, nlog = 0;
    bit done = 1'b0;
    logic [25:0] log_d [0:255];
    logic        log_h [0:255];

    always #2.5 clk = ~clk;

    dchain_rx i_dchain_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass), .din(din),
        .busy_in(busy_in), .ser_in(ser_in), .local_busy(local_busy),
        .link_out(link_out), .busy_out(busy_out), .locked(locked),
        .stuck(stuck), .buf_wr(buf_wr), .buf_hdr(buf_hdr), .buf_data(buf_data)
    );

    always @(negedge clk) begin
        if (buf_wr) begin
            if (nlog < 256) begin
                log_d[nlog] = buf_data;
                log_h[nlog] = buf_hdr;
            end
            nlog = nlog + 1;
        end
    end

    // stimulus vectors: {type[1:0], count[9:0], tag[13:0], flip mask[31:0]}
    localparam logic [57:0] VEC [0:7] = '{
        {2'd2, 10'd3, 14'h0123, 32'h0000_0000},
        {2'd1, 10'd5, 14'h00AA, 32'h0000_0000},
        {2'd2, 10'd2, 14'h1F0F, 32'h0000_0020},
        {2'd0, 10'd7, 14'h0555, 32'h0000_0000},
        {2'd2, 10'd4, 14'h0C3C, 32'h0010_0008},
        {2'd2, 10'd1, 14'h3ABC, 32'h0000_0001},
        {2'd2, 10'd0, 14'h2222, 32'h0000_0000},
        {2'd3, 10'd2, 14'h1234, 32'h0000_0000}
    };

    function automatic logic [31:0] tb_enc(logic [25:0] d);
        logic [31:0] c = '0;
        logic [4:0]  s = '0;
        int k = 0;
        for (int p = 3; p < 32; p++) begin
            if (p != 4 && p != 8 && p != 16) begin
                c[p] = d[k];
                if (d[k]) s = s ^ 5'(p);
                k++;
            end
        end
        for (int b = 0; b < 5; b++) c[1 << b] = s[b];
        c[0] = ^c;
        return c;
    endfunction

    function automatic logic [9:0] pat(int v, int k);
        return 10'(v * 37 + k * 11 + 5);
    endfunction

    localparam logic [31:0] TB_SYNC = tb_enc(26'h2D36B0);

    task automatic check(bit ok, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        din = b;
        @(negedge clk);
    endtask

    task automatic send_cw(logic [31:0] c);
        for (int i = 31; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_word(logic [9:0] w);
        for (int i = 9; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic relock();
        for (int i = 0; i < 3; i++) send_cw(TB_SYNC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check(locked == 1'b0, "R1 reset locked", locked, 0);
        check(stuck == 1'b0, "R1 reset stuck", stuck, 0);
        check(buf_wr == 1'b0, "R1 reset buf_wr", buf_wr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // two syncs then a data header: must not lock
        base = nlog;
        send_cw(TB_SYNC);
        send_cw(TB_SYNC);
        send_cw(tb_enc({14'h0777, 10'd0, 2'd2}));
        check(locked == 1'b0, "R1 no lock after two syncs", locked, 0);
        check(nlog == base, "R1 no write before lock", nlog - base, 0);
        relock();
        check(locked == 1'b1, "R1 lock after three syncs", locked, 1);

        // vector table
        for (int v = 0; v < 8; v++) begin
            logic [1:0]  ty;
            logic [9:0]  wc;
            logic [25:0] d;
            int          flips, expw;
            bit          drop;
            ty    = VEC[v][57:56];
            wc    = VEC[v][55:46];
            d     = {VEC[v][45:32], wc, ty};
            flips = $countones(VEC[v][31:0]);
            drop  = (flips >= 2);
            base  = nlog;
            send_cw(tb_enc(d) ^ VEC[v][31:0]);
            if (ty == 2'd2)
                for (int k = 0; k < int'(wc); k++) send_word(pat(v, k));
            send_cw(TB_SYNC);
            expw = drop ? 0 : (ty == 2'd1) ? 1 : (ty == 2'd2) ? 1 + int'(wc) : 0;
            if (drop)
                check(nlog - base == expw, "R4 double error write count", nlog - base, expw);
            else if (ty == 2'd0 || ty == 2'd3)
                check(nlog - base == expw, "R2 discarded type write count", nlog - base, expw);
            else
                check(nlog - base == expw, "R5 write count", nlog - base, expw);
            if (expw > 0) begin
                check(log_h[base] == 1'b1 && log_d[base] == d, "R3 R9 corrected header",
                      log_d[base], d);
                if (ty == 2'd2 && wc != 10'd0)
                    check(log_h[base + int'(wc)] == 1'b0 &&
                          log_d[base + int'(wc)] == {16'b0, pat(v, int'(wc) - 1)},
                          "R5 last payload word", log_d[base + int'(wc)],
                          {16'b0, pat(v, int'(wc) - 1)});
            end
            if (drop) begin
                check(locked == 1'b0, "R4 lock lost on double error", locked, 0);
                relock();
            end
            check(locked == 1'b1, "R1 locked after vector", locked, 1);
        end

        // stuck-low detection
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 0; i < 63; i++) send_bit(1'b0);
        check(stuck == 1'b0, "R6 no stuck after 63", stuck, 0);
        send_bit(1'b0);
        check(stuck == 1'b1, "R6 stuck after 64", stuck, 1);
        send_bit(1'b0);
        check(locked == 1'b0, "R6 lock lost on stuck", locked, 0);
        send_bit(1'b1);
        check(stuck == 1'b0, "R6 stuck cleared by toggle", stuck, 0);

        // bypass routing and receiver freeze
        bypass = 1'b1; busy_in = 1'b1; local_busy = 1'b0; ser_in = 1'b0; din = 1'b1;
        #1;
        check(link_out == 1'b1 && busy_out == 1'b1, "R7 bypass path high",
              {link_out, busy_out}, 2'b11);
        din = 1'b0; busy_in = 1'b0;
        #1;
        check(link_out == 1'b0 && busy_out == 1'b0, "R7 bypass path low",
              {link_out, busy_out}, 2'b00);
        @(negedge clk);
        base = nlog;
        relock();
        check(locked == 1'b0 && nlog == base, "R7 receiver frozen in bypass", locked, 0);
        bypass = 1'b0; ser_in = 1'b1; local_busy = 1'b1; din = 1'b0;
        #1;
        check(link_out == 1'b1 && busy_out == 1'b1, "R7 local path",
              {link_out, busy_out}, 2'b11);
        @(negedge clk);

        // enable freeze mid-header
        relock();
        check(locked == 1'b1, "R1 relock after bypass", locked, 1);
        begin
            logic [31:0] c;
            logic [25:0] d;
            d = {14'h00F0, 10'd1, 2'd2};
            c = tb_enc(d);
            base = nlog;
            for (int i = 31; i >= 16; i--) send_bit(c[i]);
            en = 1'b0;
            for (int i = 0; i < 20; i++) send_bit(i[0]);
            check(nlog == base && locked == 1'b1, "R8 frozen holds state", nlog - base, 0);
            en = 1'b1;
            for (int i = 15; i >= 0; i--) send_bit(c[i]);
            send_word(10'h2B5);
            send_cw(TB_SYNC);
            check(nlog - base == 2, "R8 resume write count", nlog - base, 2);
            check(log_d[base] == d && log_d[base + 1] == 26'h2B5, "R8 resume data",
                  log_d[base], d);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule